// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block lets a host microcontroller reach a bank of 16-bit control and status registers over a three-wire serial bus. The three wires are a bus clock, a mode line and a bidirectional data line. The mode line frames the traffic instead of a chip select. While the mode line is low, the host sends a selection byte. That byte holds a 6-bit device address and a two-bit transfer code. While the mode line is high, the host sends or receives the payload bytes. Every byte goes least significant bit first.

The three bus inputs pass through synchronizers into the system clock domain, where their edges are detected. The system clock must run at least eight times faster than the bus clock. A write transfer sends a register-addressing byte and then two data bytes, which produce one write strobe on a generic register-file port. A read is done in two steps. A prepare step names the register. A later read transfer returns a status byte carrying the address and a validity flag, and then the register contents. Data leaves the block on a separate output with an output enable, so the pad can be tri-stated.

Top module: `l3s_slave`

## Requirements
- R1: Bits are taken from the data line on rising bus clock edges and placed on it after falling edges, least significant bit first in both directions.
- R2: In the selection byte, bits 7..2 must equal the parameter DEV_ADDR. Bits 1..0 give the transfer code: 2'b10 selects write/prepare, 2'b11 selects read, and 2'b00 or 2'b01 select nothing.
- R3: After reset the first rising bus clock edge only wakes the interface and carries no bit, so a transfer that supplies no extra wake pulse has no effect.
- R4: In a write/prepare transfer, the first payload byte holds the register address in bits 7..1. Bit 0 of that byte is 0 for a write and 1 to prepare a read.
- R5: A write takes the low data byte and then the high data byte. After the high byte it raises reg_wr_en for exactly one cycle, with the address and the data. Further bytes in the same transfer are ignored.
- R6: A write to an address at or above NUM_REGS produces no strobe.
- R7: A read transfer returns three bytes in this order: a status byte {prepared address, bit0}, the low data byte, then the high data byte. bit0 is 0 when the address is below NUM_REGS and 1 when it is not. For an address that is not below NUM_REGS, both data bytes are zero.
- R8: bus_data_oe is 1 only while the mode line is high in a selected read transfer, and 0 at all other times. bus_data_o changes only on a falling bus clock edge or at the start of such a transfer.
- R9: Any change of the mode line clears the bit and byte counters. A partly received byte or write is then dropped without a strobe.
- R10: After a selection byte whose device address does not match, the block ignores data mode until the next address mode: no strobe, and the output enable stays low.
- R11: After reset, bus_data_oe, bus_data_o and reg_wr_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Serial bus clock from host |
| bus_mode_i | input | 1 | Mode line: low = selection byte, high = payload |
| bus_data_i | input | 1 | Data line as seen at the pad |
| bus_data_o | output | 1 | Data driven back during reads |
| bus_data_oe | output | 1 | Output enable for the data pad |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 7 | Register write address |
| reg_wr_data | output | DATA_W | Register write data |
| reg_rd_addr | output | 7 | Prepared register read address |
| reg_rd_data | input | DATA_W | Register contents at reg_rd_addr |

## Verification
Some properties are checked on every cycle. A write strobe always lasts a single cycle and always names an implemented address. No strobe occurs before wake-up, right after a mode change, or while a read is being driven. The output enable rises only when the mode line rises, and the driven bit holds steady between falling bus clock edges. Other behaviour appears only in the bench scenarios:
- the order of bits and bytes;
- the values of the status byte;
- the masking of invalid reads;
- the rejection of mismatched device addresses and unused transfer codes;
- recovery after a mode glitch in the middle of a byte.

// File: rtl/l3s_pkg.sv
package l3s_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_WR   = 2'd1,
    SEL_RD   = 2'd2
  } sel_e;

  localparam logic [1:0] CODE_WR = 2'b10;
  localparam logic [1:0] CODE_RD = 2'b11;
endpackage

// File: rtl/l3s_sync.sv
module l3s_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/l3s_edge.sv
module l3s_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end
  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/l3s_tx.sv
module l3s_tx #(
  parameter int W = 24
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] word,
  output logic         dout
);
  logic [W-2:0] rest;
  always_ff @(posedge clk) begin
    if (rst) begin
      rest <= '0;
      dout <= 1'b0;
    end else if (load) begin
      rest <= word[W-1:1];
      dout <= word[0];
    end else if (shift) begin
      rest <= rest >> 1;
      dout <= rest[0];
    end
  end
endmodule

// File: rtl/l3s_slave.sv
module l3s_slave
  import l3s_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR    = 6'h1A,
  parameter int         NUM_REGS    = 32,
  parameter int         DATA_W      = 16,
  parameter int         SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_clk_i,
  input  logic              bus_mode_i,
  input  logic              bus_data_i,
  output logic              bus_data_o,
  output logic              bus_data_oe,
  output logic              reg_wr_en,
  output logic [6:0]        reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [6:0]        reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data
);
  localparam int         NBYTES = DATA_W / 8;
  localparam int         IDX_W  = $clog2(NBYTES + 2);
  localparam int         TXW    = DATA_W + 8;
  localparam logic [7:0] LIMIT  = (NUM_REGS > 127) ? 8'd128 : 8'(NUM_REGS);

  logic [2:0] syn;
  logic       s_clk, s_mode, s_data;
  logic       ck_rise, ck_fall, md_rise, md_fall, mode_chg;

  l3s_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .din({bus_data_i, bus_mode_i, bus_clk_i}),
    .dout(syn)
  );
  assign s_clk  = syn[0];
  assign s_mode = syn[1];
  assign s_data = syn[2];

  l3s_edge u_ck (.clk(clk), .rst(rst), .lvl(s_clk),  .rise(ck_rise), .fall(ck_fall));
  l3s_edge u_md (.clk(clk), .rst(rst), .lvl(s_mode), .rise(md_rise), .fall(md_fall));
  assign mode_chg = md_rise | md_fall;

  logic              woken;
  logic [2:0]        bit_cnt;
  logic [6:0]        sr;
  logic [7:0]        nxt;
  sel_e              sel;
  logic [IDX_W-1:0]  byte_idx;
  logic              wr_mode;
  logic [6:0]        wr_addr;
  logic [DATA_W-9:0] wr_buf;
  logic [DATA_W-1:0] wr_cat;
  logic [6:0]        prep_addr;
  logic              prep_ok;
  logic              take_bit;

  assign nxt      = {s_data, sr};
  assign wr_cat   = {nxt, wr_buf};
  assign prep_ok  = {1'b0, prep_addr} < LIMIT;
  assign take_bit = woken && (!s_mode || sel == SEL_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      woken       <= 1'b0;
      bit_cnt     <= '0;
      sr          <= '0;
      sel         <= SEL_NONE;
      byte_idx    <= '0;
      wr_mode     <= 1'b0;
      wr_addr     <= '0;
      wr_buf      <= '0;
      prep_addr   <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
      bus_data_oe <= 1'b0;
    end else begin
      reg_wr_en   <= 1'b0;
      bus_data_oe <= s_mode && (sel == SEL_RD);
      if (mode_chg) begin
        bit_cnt  <= '0;
        byte_idx <= '0;
        if (md_fall) sel <= SEL_NONE;
      end else if (ck_rise) begin
        if (!woken) begin
          woken <= 1'b1;
        end else if (take_bit) begin
          sr <= nxt[7:1];
          if (bit_cnt != 3'd7) begin
            bit_cnt <= bit_cnt + 3'd1;
          end else begin
            bit_cnt <= '0;
            if (!s_mode) begin
              if (nxt[7:2] != DEV_ADDR)       sel <= SEL_NONE;
              else if (nxt[1:0] == CODE_WR)   sel <= SEL_WR;
              else if (nxt[1:0] == CODE_RD)   sel <= SEL_RD;
              else                            sel <= SEL_NONE;
            end else begin
              if (byte_idx != IDX_W'(NBYTES + 1)) byte_idx <= byte_idx + 1'b1;
              if (byte_idx == '0) begin
                wr_mode <= ~nxt[0];
                if (nxt[0]) prep_addr <= nxt[7:1];
                else        wr_addr   <= nxt[7:1];
              end else if (wr_mode && byte_idx <= IDX_W'(NBYTES)) begin
                wr_buf <= wr_cat[DATA_W-1:8];
                if (byte_idx == IDX_W'(NBYTES) && ({1'b0, wr_addr} < LIMIT)) begin
                  reg_wr_en   <= 1'b1;
                  reg_wr_addr <= wr_addr;
                  reg_wr_data <= wr_cat;
                end
              end
            end
          end
        end
      end
    end
  end

  assign reg_rd_addr = prep_addr;

  logic [TXW-1:0] tx_word;
  assign tx_word = {(prep_ok ? reg_rd_data : {DATA_W{1'b0}}), prep_addr, ~prep_ok};

  l3s_tx #(.W(TXW)) u_tx (
    .clk(clk), .rst(rst),
    .load(md_rise && sel == SEL_RD),
    .shift(ck_fall && s_mode && sel == SEL_RD && !mode_chg),
    .word(tx_word),
    .dout(bus_data_o)
  );
endmodule

// File: rtl/l3s_checker.sv
module l3s_checker #(
  parameter int NUM_REGS = 32
)(
  input logic       clk,
  input logic       rst,
  input logic       reg_wr_en,
  input logic [6:0] reg_wr_addr,
  input logic       bus_data_oe,
  input logic       bus_data_o,
  input logic       woken,
  input logic       md_rise,
  input logic       ck_fall,
  input logic       mode_chg
);
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en); // R5
  AST_WR_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> (int'(reg_wr_addr) < NUM_REGS)); // R6
  AST_NO_WR_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    !woken |-> !reg_wr_en); // R3
  AST_OE_ON_MODE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_data_oe) |-> $past(md_rise)); // R8
  AST_DOUT_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (bus_data_oe && $past(bus_data_oe) && !$past(ck_fall)) |-> $stable(bus_data_o)); // R8
  AST_NO_WR_DURING_READ: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> !reg_wr_en); // R7
  AST_ABORT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !reg_wr_en); // R9
endmodule

bind l3s_slave l3s_checker #(.NUM_REGS(NUM_REGS)) u_l3s_checker (
  .clk(clk), .rst(rst),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
  .bus_data_oe(bus_data_oe), .bus_data_o(bus_data_o),
  .woken(woken), .md_rise(md_rise), .ck_fall(ck_fall), .mode_chg(mode_chg)
);

// File: tb/l3s_slave_bench.sv
module l3s_slave_bench;
  localparam logic [5:0] DEV  = 6'h1A;
  localparam int         NREG = 32;
  localparam int         HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_clk = 1'b0, bus_mode = 1'b0, bus_din = 1'b0;
  logic        dout, oe, wr_en;
  logic [6:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;

  always #5 clk = ~clk;

  l3s_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .DATA_W(16), .SYNC_STAGES(2)) u_l3s_slave (
    .clk(clk), .rst(rst),
    .bus_clk_i(bus_clk), .bus_mode_i(bus_mode), .bus_data_i(bus_din),
    .bus_data_o(dout), .bus_data_oe(oe),
    .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
    .reg_rd_addr(rd_addr), .reg_rd_data(rd_data)
  );

  logic [15:0] mem [128];
  int          wr_count = 0;
  logic [6:0]  last_addr = '0;
  logic [15:0] last_data = '0;
  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      last_addr    <= wr_addr;
      last_data    <= wr_data;
      wr_count     <= wr_count + 1;
    end
  end
  assign rd_data = (int'(rd_addr) < NREG) ? mem[rd_addr] : 16'hBEEF;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic b, output logic r);
    bus_din = b;
    repeat (HALF) @(posedge clk); #1;
    r = dout;
    bus_clk = 1'b1;
    repeat (HALF) @(posedge clk); #1;
    bus_clk = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    repeat (2*HALF) @(posedge clk); #1;
    bus_mode = m;
    repeat (2*HALF) @(posedge clk); #1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic r;
    for (int i = 0; i < 8; i++) bus_bit(b[i], r);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic r;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b0, r);
      v[i] = r;
    end
  endtask

  task automatic select(input logic [5:0] dev, input logic [1:0] code);
    set_mode(1'b0);
    send_byte({dev, code});
    set_mode(1'b1);
  endtask

  task automatic do_write(input logic [5:0] dev, input logic [6:0] a, input logic [15:0] d);
    select(dev, 2'b10);
    send_byte({a, 1'b0});
    send_byte(d[7:0]);
    send_byte(d[15:8]);
    set_mode(1'b0);
  endtask

  task automatic do_prep(input logic [6:0] a);
    select(DEV, 2'b10);
    send_byte({a, 1'b1});
    set_mode(1'b0);
  endtask

  task automatic do_read(input logic [5:0] dev, output logic [7:0] st, output logic [15:0] d, output logic oe_seen);
    select(dev, 2'b11);
    oe_seen = oe;
    recv_byte(st);
    recv_byte(d[7:0]);
    recv_byte(d[15:8]);
    set_mode(1'b0);
  endtask

  localparam logic [22:0] VEC [4] = '{
    {7'd0,  16'h1234},
    {7'd5,  16'hA55A},
    {7'd31, 16'h8001},
    {7'd17, 16'h00FF}
  };

  initial begin
    logic [7:0]  st;
    logic [15:0] d;
    logic        oes;
    logic        r;
    int          c0;
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R11 oe after reset", oe, 0);
    check("R11 data_o after reset", dout, 0);
    check("R11 wr_en after reset", wr_en, 0);

    // R3: no wake pulse, first edge consumed so this write is lost
    do_write(DEV, 7'd3, 16'h5A5A);
    check("R3 no write before wake", wr_count, 0);

    // table walk: write, prepare, read back
    foreach (VEC[i]) begin
      c0 = wr_count;
      do_write(DEV, VEC[i][22:16], VEC[i][15:0]);
      check("R5 one strobe per write", wr_count, c0 + 1);
      check("R4 write address", last_addr, VEC[i][22:16]);
      do_prep(VEC[i][22:16]);
      do_read(DEV, st, d, oes);
      check("R7 status byte valid", st, {VEC[i][22:16], 1'b0});
      check("R1 read data lsb first", d, VEC[i][15:0]);
    end
    check("R5 write data", last_data, VEC[3][15:0]);

    // R2: unused transfer codes
    c0 = wr_count;
    select(DEV, 2'b00); send_byte({7'd2, 1'b0}); send_byte(8'h11); send_byte(8'h22); set_mode(1'b0);
    select(DEV, 2'b01); send_byte({7'd2, 1'b0}); send_byte(8'h11); send_byte(8'h22); set_mode(1'b0);
    check("R2 unused codes ignored", wr_count, c0);

    // R10: device mismatch
    do_write(DEV ^ 6'h01, 7'd4, 16'h7777);
    check("R10 mismatch write ignored", wr_count, c0);
    do_read(DEV ^ 6'h20, st, d, oes);
    check("R10 mismatch read no drive", oes, 0);

    // R6: write out of range
    do_write(DEV, 7'd40, 16'h4040);
    check("R6 out-of-range write dropped", wr_count, c0);

    // R7: prepared invalid address
    do_prep(7'd100);
    do_read(DEV, st, d, oes);
    check("R8 oe during read", oes, 1);
    check("R7 invalid status", st, {7'd100, 1'b1});
    check("R7 invalid data zero", d, 0);
    check("R8 oe released", oe, 0);

    // R5: extra bytes ignored
    select(DEV, 2'b10);
    send_byte({7'd12, 1'b0}); send_byte(8'hE1); send_byte(8'hC3); send_byte(8'h77); send_byte(8'h66);
    set_mode(1'b0);
    check("R5 extra bytes single strobe", wr_count, c0 + 1);
    check("R5 extra bytes data", last_data, 16'hC3E1);

    // R9: partial write aborted
    c0 = wr_count;
    select(DEV, 2'b10);
    send_byte({7'd9, 1'b0}); send_byte(8'h99);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, r);
    set_mode(1'b0);
    check("R9 partial write dropped", wr_count, c0);

    // R9: mode glitch mid selection byte clears bit counter
    set_mode(1'b0);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, r);
    set_mode(1'b1);
    set_mode(1'b0);
    send_byte({DEV, 2'b10});
    set_mode(1'b1);
    send_byte({7'd7, 1'b0}); send_byte(8'h3C); send_byte(8'h96);
    set_mode(1'b0);
    check("R9 recovery after glitch", wr_count, c0 + 1);
    check("R9 recovered data", last_data, 16'h963C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule